// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Emulator

This block stands in for an asynchronous, byte-maskable static RAM, 16 bits wide, on the far side of a memory controller. It is meant for a self-checking simulation or for an FPGA prototype. A fast internal clock samples the active-low pins: chip select, write strobe, read enable, two lane enables, address and write data. From each sample the block works out the operating mode from the full control table. It drives a split data bus: read data plus one drive-enable per byte lane, in place of a bidirectional bus. A status output tells whether the emulated device is drawing active or standby power.

A write is committed when the write window closes. The window closes on the first sample in which chip select or write strobe has gone high after both were low. The address, data and lane enables of the last sample inside the window are the ones stored, and only lanes enabled in that sample are changed. The address width is a parameter. `ADDR_W = 17` gives the full 131,072-word array. The default is kept small so that a default build stays light. Storage is one inferable RAM per byte lane and starts at zero.

Top module: `sram_lane_emu`

## Requirements
- R1: While the sampled chip select `cs_n` is 1, both bits of `dout_en` are 0 and `active` is 0, whatever the other pins are.
- R2: While both bits of the sampled `lane_n` are 1, both bits of `dout_en` are 0 and `active` is 0.
- R3: With `cs_n`=0, `wr_n`=1, `rd_n`=1 and at least one `lane_n` bit 0, both bits of `dout_en` are 0 and `active` is 1.
- R4: With `cs_n`=0, `wr_n`=1 and `rd_n`=0, `dout_en[i]` is 1 exactly for each lane i whose `lane_n[i]` is 0. Lane 0 is `dout[7:0]` and lane 1 is `dout[15:8]`. A driven lane carries the stored byte at the sampled address, and `active` is 1.
- R5: With `cs_n`=0, `wr_n`=0 and a lane enabled, `rd_n` has no effect: both bits of `dout_en` are 0 and `active` is 1.
- R6: A write is committed when `cs_n` OR `wr_n` goes from 0 (both low) in one sample to 1 in the next. The stored values are the address and data of the earlier sample, and a read of that address afterwards returns them.
- R7: The lanes changed by a commit are exactly those with `lane_n` 0 in the last sample of the write. A lane disabled in that sample keeps its old byte, even if it was enabled earlier in the same write.
- R8: Pins are registered on each clock edge. `dout_en`, `active` and `dout` take the values implied by that sample one edge later.
- R9: Every storage word reads as zero until it is first written.
- R10: A synchronous active-high `rst` forces `dout_en` and `active` to 0. The pin samples are set to an idle state, so no commit follows the release of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read (output) enable, active low |
| lane_n | input | LANES | Byte-lane enables, active low; bit 0 = low byte |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data; valid on lanes whose `dout_en` bit is 1 |
| dout_en | output | LANES | Per-lane drive enable (0 = high impedance) |
| active | output | 1 | 1 in active power state, 0 in standby |

## Verification
The bench builds the block with `ADDR_W = 6`, a 64-word array, and keeps the two 8-bit lanes. The small array lets long random traffic land on the same words many times. That brings read-after-write, partial-lane overwrite and write windows closed by either strobe within reach, together with the lane mask changing inside a window. The directed part covers every row of the control table. A lane-mask change while the strobes stay low is shown to commit only the final mask.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_QUIET   = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } mode_e;

  // Control-table decode. any_lane is 1 when at least one lane enable is low.
  function automatic mode_e decode_mode(input logic cs_n, input logic wr_n,
                                        input logic rd_n, input logic any_lane);
    mode_e m;
    if (cs_n || !any_lane)  m = MODE_STANDBY;
    else if (!wr_n)         m = MODE_WRITE;
    else if (!rd_n)         m = MODE_READ;
    else                    m = MODE_QUIET;
    return m;
  endfunction

endpackage

// File: rtl/sram_emu_sampler.sv
module sram_emu_sampler
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output mode_e             mode,
  output logic [LANES-1:0]  rd_lanes,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LANES-1:0]  wr_lanes,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  // Current sample (cur_*) and the one before it (old_*).
  logic              cur_cs_n, cur_wr_n, cur_rd_n;
  logic [LANES-1:0]  cur_lane_n;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_din;
  logic              old_cs_n, old_wr_n;
  logic [LANES-1:0]  old_lane_n;
  logic [ADDR_W-1:0] old_addr;
  logic [DATA_W-1:0] old_din;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_cs_n   <= 1'b1;
      cur_wr_n   <= 1'b1;
      cur_rd_n   <= 1'b1;
      cur_lane_n <= '1;
      cur_addr   <= '0;
      cur_din    <= '0;
      old_cs_n   <= 1'b1;
      old_wr_n   <= 1'b1;
      old_lane_n <= '1;
      old_addr   <= '0;
      old_din    <= '0;
    end else begin
      cur_cs_n   <= cs_n;
      cur_wr_n   <= wr_n;
      cur_rd_n   <= rd_n;
      cur_lane_n <= lane_n;
      cur_addr   <= addr;
      cur_din    <= din;
      old_cs_n   <= cur_cs_n;
      old_wr_n   <= cur_wr_n;
      old_lane_n <= cur_lane_n;
      old_addr   <= cur_addr;
      old_din    <= cur_din;
    end
  end

  logic window_was_open;
  logic window_closed;

  always_comb begin
    mode            = decode_mode(cur_cs_n, cur_wr_n, cur_rd_n, ~&cur_lane_n);
    rd_lanes        = ~cur_lane_n;
    rd_addr         = cur_addr;
    window_was_open = !old_cs_n && !old_wr_n;
    window_closed   = window_was_open && (cur_cs_n || cur_wr_n);
    wr_lanes        = window_closed ? ~old_lane_n : '0;
    wr_addr         = old_addr;
    wr_data         = old_din;
  end

  // R6: a closed window commits once; the next sample cannot close it again.
  a_r6_one_commit_per_close: assert property (@(posedge clk) disable iff (rst)
    (wr_lanes != '0) |=> (wr_lanes == '0));

  // R10: the first sample after reset never closes a window.
  a_r10_no_commit_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (wr_lanes == '0));

endmodule

// File: rtl/sram_emu_lane_array.sv
module sram_emu_lane_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [LANES-1:0]  wr_lanes,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] q;

    initial begin
      for (int i = 0; i < DEPTH; i++) store[i] = '0;
    end

    // One simple dual-port RAM per lane: registered read, old data on collision.
    always_ff @(posedge clk) begin
      if (wr_lanes[l]) store[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
      q <= store[rd_addr];
    end

    assign rd_data[l*LANE_W +: LANE_W] = q;
  end

endmodule

// File: rtl/sram_emu_drive.sv
module sram_emu_drive
  import sram_emu_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_e            mode,
  input  logic [LANES-1:0] rd_lanes,
  output logic [LANES-1:0] lane_en,
  output logic             active
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_en <= '0;
      active  <= 1'b0;
    end else begin
      lane_en <= (mode == MODE_READ) ? rd_lanes : '0;
      active  <= (mode != MODE_STANDBY);
    end
  end

  // R1/R2: standby releases both lanes and drops the status.
  a_r1_standby_released: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_STANDBY) |=> (lane_en == '0 && !active));

  // R3: output-disabled keeps the status high with the lanes released.
  a_r3_quiet_active: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_QUIET) |=> (lane_en == '0 && active));

  // R4: a read drives exactly the enabled lanes.
  a_r4_read_lanes: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_READ) |=> (lane_en == $past(rd_lanes) && active));

  // R5: a write never drives a lane.
  a_r5_write_released: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_WRITE) |=> (lane_en == '0 && active));

endmodule

// File: rtl/sram_lane_emu.sv
module sram_lane_emu
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [LANES-1:0]  dout_en,
  output logic              active
);

  mode_e             mode;
  logic [LANES-1:0]  rd_lanes;
  logic [ADDR_W-1:0] rd_addr;
  logic [LANES-1:0]  wr_lanes;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  sram_emu_sampler #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .lane_n   (lane_n),
    .addr     (addr),
    .din      (din),
    .mode     (mode),
    .rd_lanes (rd_lanes),
    .rd_addr  (rd_addr),
    .wr_lanes (wr_lanes),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  sram_emu_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk      (clk),
    .wr_lanes (wr_lanes),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (dout)
  );

  sram_emu_drive #(.LANES(LANES)) u_drive (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .rd_lanes (rd_lanes),
    .lane_en  (dout_en),
    .active   (active)
  );

  // R8: a driven lane implies the active power state.
  a_r8_drive_implies_active: assert property (@(posedge clk) disable iff (rst)
    (dout_en != '0) |-> active);

  // R10: outputs are cleared the edge after reset is seen.
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (dout_en == '0 && !active));

endmodule

// File: tb/test_sram_lane_emu.sv
`timescale 1ns/1ps
module test_sram_lane_emu;

  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [1:0] lane_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0] dout_en;
  logic active;

  always #2 clk = ~clk;

  sram_lane_emu #(.ADDR_W(AW), .LANES(2), .LANE_W(8)) i_sram_lane_emu (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .lane_n(lane_n), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .active(active)
  );

  typedef struct packed {
    logic cs; logic wr; logic rd; logic [1:0] ln; logic [AW-1:0] a; logic [15:0] d;
  } pins_t;
  localparam pins_t IDLE = '{cs:1'b1, wr:1'b1, rd:1'b1, ln:2'b11, a:'0, d:'0};

  // Reference model: memory, written-flags and the last two pin samples.
  logic [15:0] ref_mem [DEPTH];
  bit          ever_wr [DEPTH];
  pins_t s1, s2;
  logic [1:0]  exp_en;
  logic        exp_act;
  logic [15:0] exp_dout;
  string       tag_en, tag_dat;
  int compared = 0, mismatched = 0;
  bit done = 0;

  initial for (int i = 0; i < DEPTH; i++) begin ref_mem[i] = '0; ever_wr[i] = 0; end

  // R8: outputs after an edge come from the sample taken one edge before.
  always @(posedge clk) begin
    if (rst) begin
      s1 = IDLE; s2 = IDLE; exp_en = 2'b00; exp_act = 1'b0; exp_dout = '0;
      tag_en = "R10"; tag_dat = "R10";
    end else begin
      if (s1.cs) begin exp_en = 0; exp_act = 0; tag_en = "R1"; end
      else if (s1.ln == 2'b11) begin exp_en = 0; exp_act = 0; tag_en = "R2"; end
      else if (!s1.wr) begin exp_en = 0; exp_act = 1; tag_en = "R5"; end
      else if (!s1.rd) begin exp_en = ~s1.ln; exp_act = 1; tag_en = "R4"; end
      else begin exp_en = 0; exp_act = 1; tag_en = "R3"; end
      exp_dout = ref_mem[s1.a];
      tag_dat  = ever_wr[s1.a] ? "R6" : "R9";
      // R6/R7: window closes between s2 and s1; store s2 on its enabled lanes.
      if (!s2.cs && !s2.wr && (s1.cs || s1.wr)) begin
        if (!s2.ln[0]) ref_mem[s2.a][7:0]  = s2.d[7:0];
        if (!s2.ln[1]) ref_mem[s2.a][15:8] = s2.d[15:8];
        if (s2.ln != 2'b11) ever_wr[s2.a] = 1;
      end
      s2 = s1;
      s1 = '{cs:cs_n, wr:wr_n, rd:rd_n, ln:lane_n, a:addr, d:din};
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (dout_en !== exp_en) begin
        mismatched++;
        $display("FAIL %s dout_en actual=%b expected=%b at %0t", tag_en, dout_en, exp_en, $time);
      end
      compared++;
      if (active !== exp_act) begin
        mismatched++;
        $display("FAIL %s active actual=%b expected=%b at %0t", tag_en, active, exp_act, $time);
      end
      for (int l = 0; l < 2; l++) begin
        if (exp_en[l]) begin
          compared++;
          if (dout[l*8 +: 8] !== exp_dout[l*8 +: 8]) begin
            mismatched++;
            $display("FAIL %s/R7 dout lane %0d actual=%h expected=%h at %0t",
                     tag_dat, l, dout[l*8 +: 8], exp_dout[l*8 +: 8], $time);
          end
        end
      end
    end
  end

  task automatic drive(input logic c, input logic w, input logic r, input logic [1:0] ln,
                       input logic [AW-1:0] a, input logic [15:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cs_n = c; wr_n = w; rd_n = r; lane_n = ln; addr = a; din = d;
    end
  endtask

  initial begin
    // R10: reset state, then a write window open across reset must not commit.
    drive(0, 0, 1, 2'b00, 6'd9, 16'hDEAD, 2);
    drive(1, 1, 1, 2'b11, 6'd0, 16'h0, 3);
    @(negedge clk); rst = 1'b0;
    drive(1, 1, 1, 2'b11, 6'd9, 16'h0, 2);
    drive(0, 1, 0, 2'b00, 6'd9, 16'h0, 3);            // R9/R10: still zero
    // R6: word write closed by the write strobe, then word read.
    drive(0, 0, 1, 2'b00, 6'd3, 16'hA1B2, 3);
    drive(0, 1, 1, 2'b00, 6'd3, 16'h0, 1);
    drive(0, 1, 0, 2'b00, 6'd3, 16'h0, 3);            // R4 word read
    // R6: lower-lane write closed by chip select, R5 with rd_n low.
    drive(0, 0, 0, 2'b10, 6'd3, 16'h5566, 2);
    drive(1, 0, 0, 2'b10, 6'd3, 16'h0, 1);
    drive(0, 1, 0, 2'b10, 6'd3, 16'h0, 3);            // R4 lower only
    drive(0, 1, 0, 2'b01, 6'd3, 16'h0, 3);            // R4 upper only
    // R7: mask narrows to upper lane inside the window.
    drive(0, 0, 1, 2'b00, 6'd5, 16'h1234, 2);
    drive(0, 0, 1, 2'b01, 6'd5, 16'h9876, 1);
    drive(0, 1, 1, 2'b01, 6'd5, 16'h0, 1);
    drive(0, 1, 0, 2'b00, 6'd5, 16'h0, 3);            // expect 9800
    drive(0, 1, 1, 2'b10, 6'd5, 16'h0, 3);            // R3 output disabled
    drive(0, 1, 0, 2'b11, 6'd5, 16'h0, 3);            // R2 deselect
    drive(1, 1, 0, 2'b00, 6'd5, 16'h0, 3);            // R1 standby
    drive(0, 0, 1, 2'b11, 6'd7, 16'hFFFF, 2);         // R2: no lane, no commit
    drive(0, 1, 0, 2'b00, 6'd7, 16'h0, 3);
    // Random traffic over all rows.
    for (int k = 0; k < 3000; k++) begin
      drive(($urandom % 5) == 0, ($urandom % 3) == 0, $urandom % 2, 2'($urandom),
            AW'($urandom), 16'($urandom), 1 + ($urandom % 3));
    end
    drive(1, 1, 1, 2'b11, 6'd0, 16'h0, 4);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule